// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel flash with a 19-bit address and an 8-bit data bus. It watches every bus write and recognises commands. Each command is a chain of write cycles to fixed unlock addresses. From those chains it raises single-cycle requests to an internal program/erase engine for byte programs and whole-chip erases. It also keeps a one-time lock on a 16 KB boot window and switches an identification read mode on and off.

The boot window sits at the bottom of the address space by default. The `TOP_BOOT` parameter moves it to the top. Once the window is locked, a program aimed inside it never reaches the engine. Every erase request tells the engine whether to spare the window. While identification mode is on, `id_rdata` gives the manufacturer code, the device code or the lock status, picked by the address. The cell array, erase timing and the high-voltage identification path belong elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset there are no requests, identification mode is off, and the boot window is unlocked.
- R2: The four writes AA@5555h, 55@2AAAh, A0@5555h, then data D at address T raise `prog_valid` for exactly the clock after the fourth write, with `prog_addr`=T and `prog_data`=D.
- R3: The six writes AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h raise `erase_valid` for one clock. In that clock `erase_keep_boot` equals the lock state, and `prog_valid` is never high in the same clock.
- R4: A write that does not match the expected address or data of the current step sends the decoder back to idle with no request. A following write of arbitrary data is then not taken as a program target.
- R5: Unlock address matching uses only address bits 14:0, so 7D555h and 42AAAh act as 5555h and 2AAAh.
- R6: AA@5555h, 55@2AAAh, 90@5555h turns identification mode on (`id_active`=1). In that mode `id_rdata` is 1Fh at address 0 and the device code at address 1. The device code is 13h for a bottom window and 12h for a top window.
- R7: Identification mode is turned off either by AA@5555h, 55@2AAAh, F0@5555h, or by a single F0 written to any address while the decoder is idle.
- R8: The six-write chain ending in 40@5555h (otherwise identical to R3) sets the lock. The lock then stays set until reset. In identification mode, `id_rdata` at address 2 is 01h when locked and 00h when not.
- R9: A program request whose target is inside the boot window is dropped while the window is locked. The same request is passed on while the window is unlocked, and programs outside the window always pass.
- R10: The boot window is addresses 00000h–03FFFh by default, or 7C000h–7FFFFh when `TOP_BOOT`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| wr_en | input | 1 | One-clock strobe marking a completed bus write |
| addr | input | 19 | Bus address, for writes and identification reads |
| wdata | input | 8 | Bus write data |
| prog_valid | output | 1 | One-clock byte program request |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_valid | output | 1 | One-clock chip erase request |
| erase_keep_boot | output | 1 | Erase must spare the boot window |
| id_active | output | 1 | Identification mode is on |
| id_rdata | output | 8 | Identification read data, selected by `addr` |

## Verification
The assertions assume that `wr_en` is a clean one-clock strobe per bus write, with `addr` and `wdata` stable while it is high. They also assume `rst_n` has already been synchronised to `clk`. The stimulus drives every write on the falling edge and holds the strobe for exactly one period. Writes never come back to back without an idle clock between them. Identification reads change only `addr`, with `wr_en` low, so a read can never be mistaken for a command step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [14:0] KEY_A     = 15'h5555;
  localparam logic [14:0] KEY_B     = 15'h2AAA;
  localparam logic [7:0]  D_UNLOCK1 = 8'hAA;
  localparam logic [7:0]  D_UNLOCK2 = 8'h55;
  localparam logic [7:0]  D_PROG    = 8'hA0;
  localparam logic [7:0]  D_ERASE_P = 8'h80;
  localparam logic [7:0]  D_ERASE   = 8'h10;
  localparam logic [7:0]  D_LOCK    = 8'h40;
  localparam logic [7:0]  D_ID_ON   = 8'h90;
  localparam logic [7:0]  D_ID_OFF  = 8'hF0;
  localparam logic [7:0]  MFR_CODE  = 8'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_TGT, ST_E3, ST_E4, ST_E5
  } seq_st_t;

  // True when address a lies in the protected window of size 2**lg,
  // at the top or bottom of an aw-bit space.
  function automatic logic in_window(input logic [31:0] a, input int aw,
                                     input int lg, input logic top);
    logic [31:0] hi;
    logic [31:0] ones;
    hi   = a >> lg;
    ones = ((32'h1 << aw) - 32'h1) >> lg;
    return top ? (hi == ones) : (hi == 32'h0);
  endfunction

endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int KEY_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [KEY_BITS-1:0] addr_lo,
  input  logic [7:0]          wdata,
  output logic                ev_prog,
  output logic                ev_erase,
  output logic                ev_lock,
  output logic                ev_id_on,
  output logic                ev_id_off
);

  localparam logic [KEY_BITS-1:0] KA = KEY_BITS'(KEY_A);
  localparam logic [KEY_BITS-1:0] KB = KEY_BITS'(KEY_B);

  seq_st_t state_q, state_d;
  logic    at_a, at_b;

  assign at_a = (addr_lo == KA);
  assign at_b = (addr_lo == KB);

  always_comb begin
    state_d   = state_q;
    ev_prog   = 1'b0;
    ev_erase  = 1'b0;
    ev_lock   = 1'b0;
    ev_id_on  = 1'b0;
    ev_id_off = 1'b0;
    if (wr_en) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (at_a && wdata == D_UNLOCK1) state_d = ST_U1;
          else if (wdata == D_ID_OFF)     ev_id_off = 1'b1;
        end
        ST_U1: if (at_b && wdata == D_UNLOCK2) state_d = ST_U2;
        ST_U2: if (at_a) begin
          unique case (wdata)
            D_PROG:    state_d   = ST_TGT;
            D_ERASE_P: state_d   = ST_E3;
            D_ID_ON:   ev_id_on  = 1'b1;
            D_ID_OFF:  ev_id_off = 1'b1;
            default:   state_d   = ST_IDLE;
          endcase
        end
        ST_TGT: ev_prog = 1'b1;
        ST_E3:  if (at_a && wdata == D_UNLOCK1) state_d = ST_E4;
        ST_E4:  if (at_b && wdata == D_UNLOCK2) state_d = ST_E5;
        ST_E5:  if (at_a) begin
          if (wdata == D_ERASE)     ev_erase = 1'b1;
          else if (wdata == D_LOCK) ev_lock  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= ST_IDLE;
    else if (wr_en) state_q <= state_d;
  end

  AST_ABORT_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_U1 && wr_en && !(at_b && wdata == D_UNLOCK2)) |=> state_q == ST_IDLE); // R4
  AST_ABORT_STEP5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_E4 && wr_en && !(at_b && wdata == D_UNLOCK2)) |=> state_q == ST_IDLE); // R4
  AST_TGT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TGT && wr_en) |=> state_q == ST_IDLE); // R2

endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import flash_cmd_pkg::*;
#(
  parameter int   ADDR_W   = 19,
  parameter int   BOOT_LG2 = 14,
  parameter logic TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_lock,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              locked,
  output logic              tgt_in_boot
);

  logic lock_q, lock_d;

  assign lock_d      = lock_q | ev_lock;
  assign locked      = lock_q;
  assign tgt_in_boot = in_window(32'(tgt_addr), ADDR_W, BOOT_LG2, TOP_BOOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> lock_q); // R8

endmodule

// File: rtl/id_mux.sv
module id_mux
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter logic [7:0]  DEV_CODE = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_on,
  input  logic              ev_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  output logic              id_active,
  output logic [7:0]        id_rdata
);

  logic id_q, id_d;

  always_comb begin
    id_d = id_q;
    if (ev_off)     id_d = 1'b0;
    else if (ev_on) id_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= 1'b0;
    else        id_q <= id_d;
  end

  assign id_active = id_q;

  always_comb begin
    if (addr == ADDR_W'(2)) id_rdata = {7'b0, locked};
    else if (addr[0])       id_rdata = DEV_CODE;
    else                    id_rdata = MFR_CODE;
  end

  AST_ID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off |=> !id_q); // R7
  AST_ID_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ev_on |=> id_q); // R6

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int   ADDR_W   = 19,
  parameter int   DATA_W   = 8,
  parameter int   KEY_BITS = 15,
  parameter int   BOOT_LG2 = 14,
  parameter logic TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_valid,
  output logic              erase_keep_boot,
  output logic              id_active,
  output logic [7:0]        id_rdata
);

  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'h12 : 8'h13;

  logic ev_prog, ev_erase, ev_lock, ev_id_on, ev_id_off;
  logic locked, tgt_in_boot, prog_ok;
  logic prog_valid_q, erase_valid_q, keep_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;

  cmd_seq_fsm #(.KEY_BITS(KEY_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr_lo(addr[KEY_BITS-1:0]), .wdata(wdata[7:0]),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_lock(ev_lock),
    .ev_id_on(ev_id_on), .ev_id_off(ev_id_off)
  );

  boot_guard #(.ADDR_W(ADDR_W), .BOOT_LG2(BOOT_LG2), .TOP_BOOT(TOP_BOOT)) u_guard (
    .clk(clk), .rst_n(rst_n), .ev_lock(ev_lock), .tgt_addr(addr),
    .locked(locked), .tgt_in_boot(tgt_in_boot)
  );

  id_mux #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst_n(rst_n), .ev_on(ev_id_on), .ev_off(ev_id_off),
    .addr(addr), .locked(locked), .id_active(id_active), .id_rdata(id_rdata)
  );

  assign prog_ok = ev_prog && !(locked && tgt_in_boot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_valid_q  <= 1'b0;
      erase_valid_q <= 1'b0;
      keep_q        <= 1'b0;
    end else begin
      prog_valid_q  <= prog_ok;
      erase_valid_q <= ev_erase;
      if (ev_erase) keep_q <= locked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (prog_ok) begin
      paddr_q <= addr;
      pdata_q <= wdata;
    end
  end

  assign prog_valid      = prog_valid_q;
  assign prog_addr       = paddr_q;
  assign prog_data       = pdata_q;
  assign erase_valid     = erase_valid_q;
  assign erase_keep_boot = keep_q;

  AST_NO_LOCKED_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> !(locked && in_window(32'(prog_addr), ADDR_W, BOOT_LG2, TOP_BOOT))); // R9
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_valid && erase_valid)); // R3
  AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid || erase_valid) |-> $past(wr_en)); // R2
  AST_KEEP_TRACKS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> (erase_keep_boot == locked)); // R3

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        prog_valid, erase_valid, erase_keep_boot, id_active;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data, id_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_valid(erase_valid), .erase_keep_boot(erase_keep_boot),
    .id_active(id_active), .id_rdata(id_rdata)
  );

  // {expect_prog, expect_erase, addr, data}
  localparam int NV = 18;
  localparam logic [28:0] VEC [NV] = '{
    {2'b00, 19'h05555, 8'hAA}, {2'b00, 19'h02AAA, 8'h55},
    {2'b00, 19'h05555, 8'hA0}, {2'b10, 19'h12345, 8'h3C},
    {2'b00, 19'h05555, 8'hAA}, {2'b00, 19'h02AAA, 8'h55},
    {2'b00, 19'h05555, 8'hA1}, {2'b00, 19'h23456, 8'h77},
    {2'b00, 19'h7D555, 8'hAA}, {2'b00, 19'h42AAA, 8'h55},
    {2'b00, 19'h45555, 8'hA0}, {2'b10, 19'h04000, 8'h0F},
    {2'b00, 19'h05555, 8'hAA}, {2'b00, 19'h02AAA, 8'h55},
    {2'b00, 19'h05555, 8'h80}, {2'b00, 19'h05555, 8'hAA},
    {2'b00, 19'h02AAA, 8'h55}, {2'b01, 19'h05555, 8'h10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one write on a falling edge; return at the next falling edge,
  // when the registered request for this write is visible.
  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic rd(input logic [18:0] a);
    addr = a;
    #1;
  endtask

  task automatic do_reset();
    wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 prog_valid", prog_valid, 0);
    chk("R1 erase_valid", erase_valid, 0);
    chk("R1 id_active", id_active, 0);

    // Table: R2 program, R4 abort, R5 aliasing, R3 erase
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i < 4) tag = "R2";
      else if (i < 8) tag = "R4";
      else if (i < 12) tag = "R5";
      else tag = "R3";
      wr(VEC[i][26:8], VEC[i][7:0]);
      chk(tag, prog_valid, VEC[i][28]);
      chk(tag, erase_valid, VEC[i][27]);
      if (VEC[i][28]) begin
        chk({tag, " addr"}, prog_addr, VEC[i][26:8]);
        chk({tag, " data"}, prog_data, VEC[i][7:0]);
      end
      if (VEC[i][27]) chk("R3 keep unlocked", erase_keep_boot, 0);
      @(negedge clk);
      chk({tag, " pulse ends"}, prog_valid | erase_valid, 0);
    end

    // R6 identification entry and codes
    unlock(); wr(19'h05555, 8'h90);
    chk("R6 id_active", id_active, 1);
    rd(19'h00000); chk("R6 mfr", id_rdata, 8'h1F);
    rd(19'h00001); chk("R6 dev", id_rdata, 8'h13);
    rd(19'h00002); chk("R1 unlocked status", id_rdata, 8'h00);
    // R7 single F0 exit
    wr(19'h12345, 8'hF0);
    chk("R7 single exit", id_active, 0);
    // R7 three-cycle exit
    unlock(); wr(19'h05555, 8'h90);
    chk("R6 re-entry", id_active, 1);
    unlock(); wr(19'h05555, 8'hF0);
    chk("R7 long exit", id_active, 0);

    // R9 program inside window while unlocked passes
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00010, 8'h5A);
    chk("R9 unlocked boot pgm", prog_valid, 1);

    // R8 lock
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h40);
    chk("R8 no request", prog_valid | erase_valid, 0);
    unlock(); wr(19'h05555, 8'h90);
    rd(19'h00002); chk("R8 locked status", id_rdata, 8'h01);
    wr(19'h00000, 8'hF0);

    // R9 / R10 refused inside, passed just outside
    unlock(); wr(19'h05555, 8'hA0); wr(19'h01000, 8'h00);
    chk("R9 locked pgm dropped", prog_valid, 0);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h03FFF, 8'h00);
    chk("R10 top edge of window dropped", prog_valid, 0);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h04000, 8'h11);
    chk("R10 first addr outside passes", prog_valid, 1);
    chk("R10 addr", prog_addr, 19'h04000);

    // R3 erase after lock spares window
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h10);
    chk("R3 erase", erase_valid, 1);
    chk("R3 keep locked", erase_keep_boot, 1);

    // R8 sticky across commands
    unlock(); wr(19'h05555, 8'h90);
    rd(19'h00002); chk("R8 sticky", id_rdata, 8'h01);

    // R1 reset clears lock and id mode
    do_reset();
    chk("R1 id off after reset", id_active, 0);
    unlock(); wr(19'h05555, 8'h90);
    rd(19'h00002); chk("R1 lock cleared", id_rdata, 8'h00);

    finish_run();
  end

endmodule